// File: doc/BRIEF.md
# Prefix Immediate Extension Unit

This unit sits between decode and execute in a processor whose instructions are 16 bits wide. A prefix instruction places an 11-bit value in a prefix register. The instruction that retires next then sees a 16-bit immediate. Its upper 11 bits come from the prefix register and its lower 5 bits come from that instruction's own immediate field. When that following instruction retires, the prefix register returns to zero. The extended immediate for an unprefixed instruction is therefore just its 5-bit field, zero-extended.

A prefix and the instruction after it form one atomic pair. From the retirement of a prefix until the retirement of the next non-prefix instruction, the unit raises an interrupt-inhibit signal, which the interrupt controller uses to hold off acceptance. A second prefix form, the bypass prefix, loads the register in the same way. It also raises a bypass flag, so that the next memory load goes around the data cache.

The retire interface is a plain strobe with no back-pressure. The unit accepts one retirement on every cycle and never stalls the pipeline, so it has no ready output. Outputs for the retiring instruction are combinational. State changes take effect from the next cycle.

Top module: `pfx_ext_unit`

## Requirements
- R1: After reset, the prefix register is zero, and both `irq_inhibit` and `bypass_pend` are low.
- R2: A retirement with class 1 (prefix) or class 2 (bypass prefix) loads `ret_pfx_val` into the prefix register. The new value is visible from the next cycle.
- R3: `ext_imm` always equals the prefix register in bits 15:5 joined with `ret_imm5` in bits 4:0.
- R4: A retirement with class 0 (other) or class 3 (load) clears the prefix register to zero from the next cycle. During its own retirement cycle, that instruction still sees the old value on `ext_imm`.
- R5: `irq_inhibit` is high from the cycle after a prefix retires until the cycle after the next non-prefix instruction retires, and only then does it fall.
- R6: A class 2 retirement sets `bypass_pend` from the next cycle. A class 1 retirement clears it, so after back-to-back prefixes the most recent prefix decides the flag.
- R7: `bypass_pend` clears after the next non-prefix retirement, whether or not that instruction is a load.
- R8: `load_uncached` is high exactly when a class 3 (load) instruction retires while `bypass_pend` is high.
- R9: Back-to-back prefixes leave the last prefix's value in the register, and `irq_inhibit` stays high throughout.
- R10: In a cycle with `ret_vld` low, the prefix register, `irq_inhibit` and `bypass_pend` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_cls | input | 2 | Class of the retiring instruction: 0 other, 1 prefix, 2 bypass prefix, 3 load |
| ret_pfx_val | input | 11 | Immediate field carried by a prefix instruction |
| ret_imm5 | input | 5 | Short immediate field of the retiring instruction |
| ext_imm | output | 16 | Extended immediate for the retiring instruction |
| irq_inhibit | output | 1 | Hold off interrupt acceptance |
| bypass_pend | output | 1 | The next load must bypass the data cache |
| load_uncached | output | 1 | The retiring load goes around the cache |

## Verification
On every cycle, the assertions check these register transitions:
- a prefix retirement loads the register;
- a non-prefix retirement clears it and drops the inhibit and bypass state;
- a bypass prefix raises the flag;
- an idle cycle holds all of the state.

They also check that the bypass flag never stands without a pending prefix. Only the bench scenarios can show the full pairing:
- that the retiring instruction sees the old prefix before the clear;
- that chains of prefixes keep the last value and the last prefix kind;
- that an uncached load is flagged only in the right position of a random retirement stream.

// File: rtl/pfx_ext_pkg.sv
package pfx_ext_pkg;
  localparam int PFX_W = 11;
  localparam int IMM_W = 5;
  localparam int EXT_W = PFX_W + IMM_W;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_PFX   = 2'd1,
    CLS_PFXBY = 2'd2,
    CLS_LOAD  = 2'd3
  } ret_cls_e;

  function automatic logic is_prefix(input logic [1:0] c);
    return (c == CLS_PFX) || (c == CLS_PFXBY);
  endfunction
endpackage

// File: rtl/pfx_value_reg.sv
module pfx_value_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ret_vld,
  input  logic         ret_is_pfx,
  input  logic [W-1:0] pfx_in,
  output logic [W-1:0] pfx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       pfx_q <= '0;
    else if (ret_vld && ret_is_pfx)   pfx_q <= pfx_in;
    else if (ret_vld)                 pfx_q <= '0;
  end

  // R2
  pfx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && ret_is_pfx |=> pfx_q == $past(pfx_in));
  // R4
  pfx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && !ret_is_pfx |=> pfx_q == '0);
  // R10
  pfx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_vld |=> $stable(pfx_q));
endmodule

// File: rtl/pfx_pend_ctl.sv
module pfx_pend_ctl
  import pfx_ext_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ret_vld,
  input  logic [1:0] ret_cls,
  output logic       pend_q,
  output logic       byp_q
);
  logic pfx_now;
  assign pfx_now = is_prefix(ret_cls);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byp_q  <= 1'b0;
    end else if (ret_vld) begin
      pend_q <= pfx_now;
      byp_q  <= (ret_cls == CLS_PFXBY);
    end
  end

  // R5
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && !pfx_now |=> !pend_q && !byp_q);
  // R9
  pend_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && pfx_now |=> pend_q);
  // R6
  byp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && ret_cls == CLS_PFXBY |=> byp_q);
  // R7
  byp_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> pend_q);
  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_vld |=> $stable(pend_q) && $stable(byp_q));
endmodule

// File: rtl/imm_join.sv
module imm_join #(
  parameter int HI_W = 11,
  parameter int LO_W = 5,
  localparam int OUT_W = HI_W + LO_W
) (
  input  logic [HI_W-1:0]  hi,
  input  logic [LO_W-1:0]  lo,
  output logic [OUT_W-1:0] joined
);
  assign joined = {hi, lo};
endmodule

// File: rtl/pfx_ext_unit.sv
module pfx_ext_unit
  import pfx_ext_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_vld,
  input  logic [1:0]       ret_cls,
  input  logic [PFX_W-1:0] ret_pfx_val,
  input  logic [IMM_W-1:0] ret_imm5,
  output logic [EXT_W-1:0] ext_imm,
  output logic             irq_inhibit,
  output logic             bypass_pend,
  output logic             load_uncached
);
  logic [PFX_W-1:0] pfx_q;
  logic             pend_q;
  logic             byp_q;
  logic             is_pfx;

  assign is_pfx = is_prefix(ret_cls);

  pfx_value_reg #(.W(PFX_W)) u_val (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_vld    (ret_vld),
    .ret_is_pfx (is_pfx),
    .pfx_in     (ret_pfx_val),
    .pfx_q      (pfx_q)
  );

  pfx_pend_ctl u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .ret_vld (ret_vld),
    .ret_cls (ret_cls),
    .pend_q  (pend_q),
    .byp_q   (byp_q)
  );

  imm_join #(.HI_W(PFX_W), .LO_W(IMM_W)) u_join (
    .hi     (pfx_q),
    .lo     (ret_imm5),
    .joined (ext_imm)
  );

  assign irq_inhibit   = pend_q;
  assign bypass_pend   = byp_q;
  assign load_uncached = ret_vld && (ret_cls == CLS_LOAD) && byp_q;

  // R8
  uncached_needs_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_uncached |-> bypass_pend && irq_inhibit);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> ext_imm[EXT_W-1:IMM_W] == '0 && !irq_inhibit && !bypass_pend);
  // R4
  nonpfx_zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld && !is_pfx |=> ext_imm[EXT_W-1:IMM_W] == '0);
endmodule

// File: tb/test_pfx_ext_unit.sv
module test_pfx_ext_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_vld;
  logic [1:0]  ret_cls;
  logic [10:0] ret_pfx_val;
  logic [4:0]  ret_imm5;
  logic [15:0] ext_imm;
  logic        irq_inhibit, bypass_pend, load_uncached;

  int checks = 0;
  int errors = 0;

  logic [10:0] m_pfx;
  logic        m_pend, m_byp;

  always #10 clk = ~clk;

  pfx_ext_unit i_pfx_ext_unit (
    .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_cls(ret_cls),
    .ret_pfx_val(ret_pfx_val), .ret_imm5(ret_imm5), .ext_imm(ext_imm),
    .irq_inhibit(irq_inhibit), .bypass_pend(bypass_pend),
    .load_uncached(load_uncached)
  );

  function automatic logic [15:0] exp_imm(input logic [10:0] p, input logic [4:0] i);
    return {p, i};
  endfunction

  function automatic logic exp_unc(input logic v, input logic [1:0] c, input logic b);
    return v && (c == 2'd3) && b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [10:0] p,
                      input logic [4:0] i, input string tag);
    @(negedge clk);
    ret_vld = v; ret_cls = c; ret_pfx_val = p; ret_imm5 = i;
    #1;
    chk({tag, " R3 ext_imm"}, 32'(ext_imm), 32'(exp_imm(m_pfx, i)));
    chk({tag, " R5 irq_inhibit"}, 32'(irq_inhibit), 32'(m_pend));
    chk({tag, " R6 bypass_pend"}, 32'(bypass_pend), 32'(m_byp));
    chk({tag, " R8 load_uncached"}, 32'(load_uncached), 32'(exp_unc(v, c, m_byp)));
    @(posedge clk);
    if (v) begin
      if (c == 2'd1 || c == 2'd2) begin
        m_pfx = p; m_pend = 1'b1; m_byp = (c == 2'd2);
      end else begin
        m_pfx = '0; m_pend = 1'b0; m_byp = 1'b0;
      end
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; ret_vld = 1'b0; ret_cls = 2'd0; ret_pfx_val = 11'h5a5; ret_imm5 = 5'h1f;
    m_pfx = '0; m_pend = 1'b0; m_byp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ext_imm hi", 32'(ext_imm[15:5]), 32'h0);
    chk("R1 irq_inhibit", 32'(irq_inhibit), 32'h0);
    chk("R1 bypass_pend", 32'(bypass_pend), 32'h0);
    rst_n = 1'b1;

    // R2 R4: prefix then ALU use, then clear
    step(1, 2'd1, 11'h3a5, 5'h00, "R2 pfx");
    step(1, 2'd0, 11'h000, 5'h13, "R4 use");
    step(1, 2'd0, 11'h000, 5'h07, "R4 after");
    // R10: idle cycles keep prefix pending
    step(1, 2'd1, 11'h7ff, 5'h00, "R10 pfx");
    step(0, 2'd0, 11'h123, 5'h00, "R10 idle");
    step(0, 2'd3, 11'h456, 5'h0a, "R10 idle2");
    step(1, 2'd3, 11'h000, 5'h1f, "R10 use");
    // R6 R7 R8: bypass prefix then load
    step(1, 2'd2, 11'h011, 5'h00, "R6 byp");
    step(1, 2'd3, 11'h000, 5'h04, "R8 load");
    step(1, 2'd3, 11'h000, 5'h04, "R8 load2");
    // R7: bypass then non-load clears
    step(1, 2'd2, 11'h022, 5'h00, "R7 byp");
    step(1, 2'd0, 11'h000, 5'h01, "R7 alu");
    step(1, 2'd3, 11'h000, 5'h02, "R7 load");
    // R9 chained prefixes; last kind decides
    step(1, 2'd2, 11'h100, 5'h00, "R9 p1");
    step(1, 2'd1, 11'h200, 5'h00, "R9 p2");
    step(1, 2'd1, 11'h2aa, 5'h00, "R9 p3");
    step(1, 2'd3, 11'h000, 5'h1e, "R9 use");
    step(1, 2'd1, 11'h0f0, 5'h00, "R9 p4");
    step(1, 2'd2, 11'h0f1, 5'h00, "R9 p5");
    step(1, 2'd3, 11'h000, 5'h03, "R9 load");

    // constrained random stream
    for (int n = 0; n < 600; n++) begin
      logic [1:0] c;
      logic v;
      v = ($urandom % 5) != 0;
      c = 2'($urandom % 4);
      step(v, c, 11'($urandom), 5'($urandom), "RND");
    end

    // R1 reset mid-pair clears state
    step(1, 2'd2, 11'h3ff, 5'h00, "R1 pre");
    @(negedge clk);
    rst_n = 1'b0; ret_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid ext_imm hi", 32'(ext_imm[15:5]), 32'h0);
    chk("R1 mid irq_inhibit", 32'(irq_inhibit), 32'h0);
    chk("R1 mid bypass_pend", 32'(bypass_pend), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule